// File: doc/BRIEF.md
# Ripple-Carry Arithmetic/Logic Unit

This block is the arithmetic/logic unit of a simple load/store processor datapath. It takes two 32-bit operands and a 4-bit operation code and produces, within the same cycle, a 32-bit result together with a zero flag and a signed-overflow flag. It has no clock and no storage: the operands, the operation code and the unsigned-mode input are decoded and evaluated combinationally.

The datapath is a chain of identical one-bit cells. Each cell holds a full adder and a small result selector. Carries ripple upward from bit 0 to the top bit. Subtraction uses the same adder: the B operand is inverted and a carry of one is injected at bit 0. Set-on-less-than takes the signed comparison bit from the top cell and feeds it back into the "less" input of bit 0. The "less" inputs of all other cells are held at zero.

Overflow is taken from the carries on either side of the top bit. The unsigned-mode input masks it, so that unsigned add and subtract never report overflow. The zero flag is what equality tests use: subtract the operands and test for an all-zero result.

Top module: `rc_alu`

## Requirements
- R1: Operation code 0010 gives result = A + B modulo 2^32.
- R2: Operation code 0110 gives result = A - B modulo 2^32. B is inverted and a carry of one is injected at bit 0.
- R3: The logic operations act bit by bit: 0000 gives AND, 0001 gives OR, 1101 gives XOR and 1100 gives NOR. For example, with A = 0x3C0 and B = 0x0D0 they give 0x0C0, 0x3D0, 0x310 and 0xFFFFFC2F.
- R4: Operation code 0111 (set-on-less-than) gives result bit 0 = 1 exactly when A < B as signed two's-complement numbers. This holds even when A - B overflows.
- R5: For set-on-less-than, result bits 31..1 are always 0.
- R6: zero_o is 1 exactly when all 32 result bits are 0, for every operation.
- R7: For add and subtract with unsigned_i = 0, ovf_o is 1 exactly when the carry into bit 31 differs from the carry out of bit 31. This is the case when the signed result cannot be represented.
- R8: When unsigned_i = 1, ovf_o is 0 for every operation.
- R9: ovf_o is 0 for the logic operations and for set-on-less-than, whatever the operands.
- R10: Operation codes not listed above give a result of 0, so zero_o = 1 and ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_i | input | 4 | Operation code |
| unsigned_i | input | 1 | Treat add/subtract as unsigned and mask overflow |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow of add/subtract |

## Verification
The hardest situations to reach from the ports need special operand pairs. One is a carry that ripples through every cell, as in 0xFFFFFFFF + 1. The other is a set-on-less-than whose internal subtraction overflows, such as 0x7FFFFFFF against 0x80000000, where the raw sign bit gives the wrong answer. Uniform random operands seldom produce the full-length carry, so directed vectors cover both situations as well as the sign-boundary pairs around 0x7FFFFFFF and 0x80000000. A large random run then crosses every operation code, including unlisted codes, with both settings of the unsigned-mode input.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100,
        OP_XOR = 4'b1101
    } alu_op_e;

    typedef enum logic [2:0] {
        SEL_AND  = 3'd0,
        SEL_OR   = 3'd1,
        SEL_SUM  = 3'd2,
        SEL_LESS = 3'd3,
        SEL_NOR  = 3'd4,
        SEL_XOR  = 3'd5,
        SEL_NONE = 3'd6
    } cell_sel_e;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [3:0] op_i,
    output cell_sel_e  sel_o,
    output logic       invert_b_o,
    output logic       is_arith_o
);
    always_comb begin
        // bit 2 of the code is the invert-B / carry-in control
        invert_b_o = op_i[2];
        is_arith_o = 1'b0;
        unique case (op_i)
            OP_AND:  sel_o = SEL_AND;
            OP_OR:   sel_o = SEL_OR;
            OP_ADD:  begin sel_o = SEL_SUM; is_arith_o = 1'b1; end
            OP_SUB:  begin sel_o = SEL_SUM; is_arith_o = 1'b1; end
            OP_SLT:  sel_o = SEL_LESS;
            OP_NOR:  sel_o = SEL_NOR;
            OP_XOR:  sel_o = SEL_XOR;
            default: sel_o = SEL_NONE;
        endcase
    end

    always_comb begin
        if (is_arith_o) begin
            a_r1_arith_code: assert (op_i == OP_ADD || op_i == OP_SUB);
        end
    end
endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
    import alu_pkg::*;
(
    input  logic      a_i,
    input  logic      b_i,
    input  logic      cin_i,
    input  logic      less_i,
    input  logic      invert_b_i,
    input  cell_sel_e sel_i,
    output logic      sum_o,
    output logic      cout_o,
    output logic      res_o
);
    logic bx;

    always_comb begin
        bx     = b_i ^ invert_b_i;
        sum_o  = a_i ^ bx ^ cin_i;
        cout_o = (a_i & bx) | (a_i & cin_i) | (bx & cin_i);
        unique case (sel_i)
            SEL_AND:  res_o = a_i & b_i;
            SEL_OR:   res_o = a_i | b_i;
            SEL_SUM:  res_o = sum_o;
            SEL_LESS: res_o = less_i;
            SEL_NOR:  res_o = ~(a_i | b_i);
            SEL_XOR:  res_o = a_i ^ b_i;
            default:  res_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] result_i,
    input  logic             carry_into_msb_i,
    input  logic             carry_out_msb_i,
    input  logic             sum_msb_i,
    input  logic             is_arith_i,
    input  logic             unsigned_i,
    output logic             set_o,
    output logic             ovf_o,
    output logic             zero_o
);
    logic raw_ovf;

    always_comb begin
        raw_ovf = carry_into_msb_i ^ carry_out_msb_i;
        // signed less-than stays correct when the subtraction overflows
        set_o   = sum_msb_i ^ raw_ovf;
        ovf_o   = raw_ovf & is_arith_i & ~unsigned_i;
        zero_o  = ~|result_i;
    end
endmodule

// File: rtl/rc_alu.sv
module rc_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       op_i,
    input  logic             unsigned_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    cell_sel_e        sel;
    logic             invert_b;
    logic             is_arith;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] less;
    logic             set_bit;

    alu_op_decode u_decode (
        .op_i       (op_i),
        .sel_o      (sel),
        .invert_b_o (invert_b),
        .is_arith_o (is_arith)
    );

    assign carry[0] = invert_b;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            if (i == 0) begin : g_lsb
                assign less[i] = set_bit;
            end else begin : g_upper
                assign less[i] = 1'b0;
            end
            alu_bit_cell u_cell (
                .a_i        (a_i[i]),
                .b_i        (b_i[i]),
                .cin_i      (carry[i]),
                .less_i     (less[i]),
                .invert_b_i (invert_b),
                .sel_i      (sel),
                .sum_o      (sum[i]),
                .cout_o     (carry[i+1]),
                .res_o      (result_o[i])
            );
        end
    endgenerate

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .result_i         (result_o),
        .carry_into_msb_i (carry[MSB]),
        .carry_out_msb_i  (carry[WIDTH]),
        .sum_msb_i        (sum[MSB]),
        .is_arith_i       (is_arith),
        .unsigned_i       (unsigned_i),
        .set_o            (set_bit),
        .ovf_o            (ovf_o),
        .zero_o           (zero_o)
    );

    always_comb begin
        if (op_i == OP_SLT) begin
            a_r5_slt_upper_zero: assert (result_o[MSB:1] == '0);
        end
        if (unsigned_i) begin
            a_r8_unsigned_no_ovf: assert (!ovf_o);
        end
        if (op_i != OP_ADD && op_i != OP_SUB) begin
            a_r9_no_overflow: assert (!ovf_o);
        end
        if (op_i == OP_SUB && a_i == b_i) begin
            a_r6_equal_zero: assert (zero_o);
        end
        if (op_i == OP_ADD && ovf_o) begin
            a_r7_add_sign: assert (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB]);
        end
    end
endmodule

// File: tb/test_rc_alu.sv
module test_rc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a, b;
    logic [3:0]  op;
    logic        uns;
    logic [31:0] res;
    logic        zero, ovf;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    rc_alu i_rc_alu (
        .a_i(a), .b_i(b), .op_i(op), .unsigned_i(uns),
        .result_o(res), .zero_o(zero), .ovf_o(ovf)
    );

    function automatic logic [31:0] exp_res(logic [31:0] x, logic [31:0] y, logic [3:0] o);
        case (o)
            4'b0000: return x & y;
            4'b0001: return x | y;
            4'b0010: return x + y;
            4'b0110: return x - y;
            4'b0111: return {31'b0, ($signed(x) < $signed(y))};
            4'b1100: return ~(x | y);
            4'b1101: return x ^ y;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_ovf(logic [31:0] x, logic [31:0] y, logic [3:0] o, logic u);
        logic [31:0] r;
        r = exp_res(x, y, o);
        if (u) return 1'b0;
        if (o == 4'b0010) return (x[31] == y[31]) && (r[31] != x[31]);
        if (o == 4'b0110) return (x[31] != y[31]) && (r[31] != x[31]);
        return 1'b0;
    endfunction

    function automatic string req_of(logic [3:0] o);
        case (o)
            4'b0010: return "R1";
            4'b0110: return "R2";
            4'b0111: return "R4";
            4'b0000, 4'b0001, 4'b1100, 4'b1101: return "R3";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h (a=%h b=%h op=%b u=%b)", req, got, exp, a, b, op, uns);
        end
    endtask

    task automatic apply(logic [31:0] x, logic [31:0] y, logic [3:0] o, logic u);
        logic [31:0] er;
        @(negedge clk);
        a = x; b = y; op = o; uns = u;
        #2;
        er = exp_res(x, y, o);
        check(req_of(o), res, er);
        check("R6", {31'b0, zero}, {31'b0, (er == 32'h0)});
        if (u) check("R8", {31'b0, ovf}, 32'h0);
        else if (o == 4'b0010 || o == 4'b0110) check("R7", {31'b0, ovf}, {31'b0, exp_ovf(x, y, o, u)});
        else check("R9", {31'b0, ovf}, 32'h0);
        if (o == 4'b0111) check("R5", {res[31:1], 1'b0}, 32'h0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] ops [8];
        void'($urandom(32'd1234));
        ops[0] = 4'b0000; ops[1] = 4'b0001; ops[2] = 4'b0010; ops[3] = 4'b0110;
        ops[4] = 4'b0111; ops[5] = 4'b1100; ops[6] = 4'b1101; ops[7] = 4'b1010;
        a = 0; b = 0; op = 0; uns = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // idle state: zero operands with AND
        @(negedge clk);
        check("R6", {res, zero, ovf}[31:0], 32'h2);
        // R3 example values
        apply(32'h3C0, 32'h0D0, 4'b0000, 0);
        apply(32'h3C0, 32'h0D0, 4'b0001, 0);
        apply(32'h3C0, 32'h0D0, 4'b1101, 0);
        apply(32'h3C0, 32'h0D0, 4'b1100, 0);
        // R1 full-length carry ripple
        apply(32'hFFFFFFFF, 32'h1, 4'b0010, 0);
        apply(32'hFFFFFFFF, 32'h1, 4'b0010, 1);
        // R7 signed overflow boundaries
        apply(32'h7FFFFFFF, 32'h1, 4'b0010, 0);
        apply(32'h80000000, 32'hFFFFFFFF, 4'b0010, 0);
        apply(32'h80000000, 32'h1, 4'b0110, 0);
        apply(32'h7FFFFFFF, 32'hFFFFFFFF, 4'b0110, 0);
        // R8 unsigned mask on overflowing subtraction
        apply(32'h80000000, 32'h1, 4'b0110, 1);
        // R4 less-than with overflowing subtraction
        apply(32'h7FFFFFFF, 32'h80000000, 4'b0111, 0);
        apply(32'h80000000, 32'h7FFFFFFF, 4'b0111, 0);
        apply(32'h5, 32'h5, 4'b0111, 0);
        apply(32'hFFFFFFFF, 32'h0, 4'b0111, 0);
        // R6 equality through subtraction
        apply(32'hDEADBEEF, 32'hDEADBEEF, 4'b0110, 0);
        // R10 unlisted codes
        apply(32'h12345678, 32'h9ABCDEF0, 4'b1111, 0);
        apply(32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0011, 0);
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] x, y;
            x = $urandom;
            y = $urandom;
            if (($urandom % 8) == 0) y = x;
            if (($urandom % 8) == 0) x = {~x[31], 31'h7FFFFFFF};
            apply(x, y, ops[$urandom % 8], 1'($urandom % 2));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule